// File: doc/BRIEF.md
# Dual Output-Compare Channel

This block holds two output-compare channels. Both channels share one control word. Each channel watches one of three external timer counts. It compares that count with its own 16-bit compare value. When a channel is enabled and the count reaches its compare value, the channel inverts its output pin and raises a status flag. The flag can drive an interrupt line. When a channel is disabled, its pin shows a data bit that software writes. Each compare value can be buffered. A buffered write waits in a shadow register and takes effect when the selected counter reports that it has passed through zero.

The counters and their zero strobes come from outside the block, one strobe per counter. Software programs the block through a simple write port: an enable, a 3-bit address and 16 bits of data. The block has no streaming data path, so none of its ports uses valid/ready. Every port is a plain level or a single-cycle strobe.

Top module: `ocp_pair`

## Requirements
- R1: After reset both channels are disabled, both interrupt enables and both flags are 0, both buffer-disable bits are 1, both source codes and both data bits are 0, and both compare and shadow values are 0xFFFF. The pins and interrupt lines are 0.
- R2: Source code 0 selects count 0, code 1 selects count 1 and code 2 selects count 2. Count c is `cnt_in[16c+15:16c]` and its zero strobe is `zero_in[c]`.
- R3: Source codes 3 to 15 disconnect the channel. No match is ever detected, and a zero strobe never loads the shadow value.
- R4: While a channel is disabled, its pin equals its software data bit. A write to that bit shows on the pin from the cycle after the write edge.
- R5: While a channel is enabled, a write to its data bit leaves the pin unchanged. Enabling a channel keeps the pin at the level it had before the enable.
- R6: While a channel is enabled, a cycle in which the selected count equals the active compare value inverts the pin at the next edge. Equality that lasts over consecutive cycles produces only one inversion.
- R7: An enabled channel with no new match keeps its pin level.
- R8: A match sets the channel's flag. Writing 0 to the flag bit clears it and writing 1 has no effect. If a match and a clear happen in the same cycle, the match wins.
- R9: Each interrupt line is the channel's flag ANDed with its interrupt-enable bit.
- R10: With buffer-disable at 1, a compare write becomes the active value at the write edge. It is used from the next cycle on.
- R11: With buffer-disable at 0, a compare write goes only to the shadow register. The active value is loaded from the shadow at the edge that ends a cycle in which the selected counter's zero strobe is high.
- R12: Register map, where bit k belongs to channel k:
  - Address 0 (control): start in bits 1:0, buffer-disable in bits 3:2, interrupt enable in bits 5:4, flag write in bits 7:6.
  - Address 1 (source select): channel 0 code in bits 3:0, channel 1 code in bits 7:4.
  - Address 2 (software data): data bits in bits 1:0.
  - Address 3: compare value for channel 0.
  - Address 4: compare value for channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | 48 | Three 16-bit counts, packed |
| zero_in | input | 3 | Zero strobe for each count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pin_out | output | 2 | Channel output levels |
| flag_out | output | 2 | Channel match flags |
| irq_out | output | 2 | Channel interrupt lines |

## Verification
The counts are driven in several patterns, and each pattern separates a different fault:
- A rising sweep through the compare value shows that the toggle happens at the right edge.
- A count held at the compare value shows that a long equality gives only one inversion, not one per cycle.
- Sweeps that pass the compare value on an unselected counter, or under a prohibited code, show that the decode is correct.
- Zero strobes, given with and without buffering and under both valid and invalid codes, separate a compare update that is immediate from one that is deferred.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  localparam int unsigned SEL_W  = 4;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_SEL  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_SWD  = 3'd2;
  localparam int unsigned       CMP_BASE = 3;

  typedef struct packed {
    logic             start;
    logic             bufdis;
    logic             ie;
    logic             sw;
    logic [SEL_W-1:0] sel;
  } ch_cfg_t;

endpackage

// File: rtl/ocp_regs.sv
module ocp_regs
  import ocp_pkg::*;
#(
  parameter int unsigned N_CH = 2,
  parameter int unsigned CW   = 4 * N_CH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [CW-1:0]         wr_data,
  output ch_cfg_t [N_CH-1:0]    cfg_o,
  output logic    [N_CH-1:0]    flag_clr_o
);

  logic ctrl_wr, sel_wr, swd_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);
  assign sel_wr  = wr_en && (wr_addr == ADR_SEL);
  assign swd_wr  = wr_en && (wr_addr == ADR_SWD);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_o[g].start  <= 1'b0;
        cfg_o[g].bufdis <= 1'b1;
        cfg_o[g].ie     <= 1'b0;
        cfg_o[g].sw     <= 1'b0;
        cfg_o[g].sel    <= '0;
      end else begin
        if (ctrl_wr) begin
          cfg_o[g].start  <= wr_data[g];
          cfg_o[g].bufdis <= wr_data[N_CH + g];
          cfg_o[g].ie     <= wr_data[2*N_CH + g];
        end
        if (sel_wr) cfg_o[g].sel <= wr_data[SEL_W*g +: SEL_W];
        if (swd_wr) cfg_o[g].sw  <= wr_data[g];
      end
    end

    assign flag_clr_o[g] = ctrl_wr && !wr_data[3*N_CH + g];
  end

endmodule

// File: rtl/ocp_srcsel.sv
module ocp_srcsel #(
  parameter int unsigned N_SRC = 3,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 4
) (
  input  logic [N_SRC*CNT_W-1:0] cnt_i,
  input  logic [N_SRC-1:0]       zero_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic [CNT_W-1:0]       cnt_o,
  output logic                   zero_o,
  output logic                   valid_o
);

  logic [N_SRC-1:0] hit;

  for (genvar s = 0; s < N_SRC; s++) begin : g_dec
    assign hit[s] = (sel_i == SEL_W'(s));
  end

  always_comb begin
    cnt_o = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (hit[s]) cnt_o = cnt_o | cnt_i[s*CNT_W +: CNT_W];
    end
  end

  assign zero_o  = |(hit & zero_i);
  assign valid_o = |hit;

endmodule

// File: rtl/ocp_channel.sv
module ocp_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bufdis_i,
  input  logic             sw_i,
  input  logic [CNT_W-1:0] src_cnt_i,
  input  logic             src_zero_i,
  input  logic             src_valid_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic             flag_clr_i,
  output logic             pin_o,
  output logic             flag_o
);

  logic [CNT_W-1:0] cmp_act_q, cmp_shd_q;
  logic             match, evt, match_q, run_q, flag_q;

  assign match = start_i && src_valid_i && (src_cnt_i == cmp_act_q);
  assign evt   = match && !match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act_q <= '1;
      cmp_shd_q <= '1;
    end else begin
      if (cmp_wr_i) cmp_shd_q <= cmp_data_i;
      if (cmp_wr_i && bufdis_i)          cmp_act_q <= cmp_data_i;
      else if (!bufdis_i && src_zero_i)  cmp_act_q <= cmp_shd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      run_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      match_q <= match;
      if (!start_i)  run_q <= sw_i;
      else if (evt)  run_q <= ~run_q;
      if (evt)             flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign pin_o  = start_i ? run_q : sw_i;
  assign flag_o = flag_q;

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);

  // R6
  pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (run_q != $past(run_q)));

  // R7
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !evt) |=> $stable(run_q));

  // R10
  cmp_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_i && bufdis_i) |=> (cmp_act_q == $past(cmp_data_i)));

  // R11
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bufdis_i && !src_zero_i) |=> $stable(cmp_act_q));

endmodule

// File: rtl/ocp_pair.sv
module ocp_pair
  import ocp_pkg::*;
#(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC*CNT_W-1:0] cnt_in,
  input  logic [N_SRC-1:0]       zero_in,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [N_CH-1:0]        pin_out,
  output logic [N_CH-1:0]        flag_out,
  output logic [N_CH-1:0]        irq_out
);

  localparam int unsigned CW = 4 * N_CH;

  ch_cfg_t [N_CH-1:0] cfg;
  logic    [N_CH-1:0] flag_clr;

  ocp_regs #(.N_CH(N_CH), .CW(CW)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data[CW-1:0]),
    .cfg_o      (cfg),
    .flag_clr_o (flag_clr)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_CMP = ADDR_W'(CMP_BASE + g);

    logic [CNT_W-1:0] s_cnt;
    logic             s_zero, s_valid, cmp_wr;

    assign cmp_wr = wr_en && (wr_addr == MY_CMP);

    ocp_srcsel #(.N_SRC(N_SRC), .CNT_W(CNT_W), .SEL_W(SEL_W)) i_sel (
      .cnt_i   (cnt_in),
      .zero_i  (zero_in),
      .sel_i   (cfg[g].sel),
      .cnt_o   (s_cnt),
      .zero_o  (s_zero),
      .valid_o (s_valid)
    );

    ocp_channel #(.CNT_W(CNT_W)) i_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (cfg[g].start),
      .bufdis_i    (cfg[g].bufdis),
      .sw_i        (cfg[g].sw),
      .src_cnt_i   (s_cnt),
      .src_zero_i  (s_zero),
      .src_valid_i (s_valid),
      .cmp_wr_i    (cmp_wr),
      .cmp_data_i  (wr_data[CNT_W-1:0]),
      .flag_clr_i  (flag_clr[g]),
      .pin_o       (pin_out[g]),
      .flag_o      (flag_out[g])
    );

    assign irq_out[g] = flag_out[g] && cfg[g].ie;
  end

endmodule

// File: tb/test_ocp_pair.sv
module test_ocp_pair;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] c [3];
  logic [2:0]  zero_in = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  pin_out, flag_out, irq_out;
  logic [47:0] cnt_in;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit run_cmp = 1'b0;

  assign cnt_in = {c[2], c[1], c[0]};

  always #4 clk = ~clk;

  ocp_pair i_ocp_pair (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .zero_in(zero_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_out(pin_out), .flag_out(flag_out), .irq_out(irq_out)
  );

  // Behavioural reference model
  bit          m_start[2], m_bd[2], m_ie[2], m_sw[2], m_mq[2], m_run[2], m_flag[2];
  int          m_sel[2];
  logic [15:0] m_cmp[2], m_shd[2];
  bit          t_match, t_evt, t_z, t_clr, t_cw;
  logic [15:0] t_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_start[i] = 0; m_bd[i] = 1; m_ie[i] = 0; m_sw[i] = 0; m_sel[i] = 0;
        m_cmp[i] = 16'hFFFF; m_shd[i] = 16'hFFFF; m_mq[i] = 0; m_run[i] = 0; m_flag[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        t_cnt   = (m_sel[i] < 3) ? c[m_sel[i]] : 16'h0;
        t_z     = (m_sel[i] < 3) && zero_in[m_sel[i]];
        t_match = m_start[i] && (m_sel[i] < 3) && (t_cnt == m_cmp[i]);
        t_evt   = t_match && !m_mq[i];
        t_clr   = wr_en && wr_addr == 3'd0 && !wr_data[6+i];
        t_cw    = wr_en && wr_addr == 3'(3 + i);
        m_mq[i] = t_match;
        if (!m_start[i]) m_run[i] = m_sw[i];
        else if (t_evt)  m_run[i] = !m_run[i];
        if (t_evt) m_flag[i] = 1;
        else if (t_clr) m_flag[i] = 0;
        if (t_cw && m_bd[i]) m_cmp[i] = wr_data;
        else if (!m_bd[i] && t_z) m_cmp[i] = m_shd[i];
        if (t_cw) m_shd[i] = wr_data;
      end
      if (wr_en) begin
        for (int i = 0; i < 2; i++) begin
          case (wr_addr)
            3'd0: begin m_start[i] = wr_data[i]; m_bd[i] = wr_data[2+i]; m_ie[i] = wr_data[4+i]; end
            3'd1: m_sel[i] = int'(wr_data[4*i +: 4]);
            3'd2: m_sw[i] = wr_data[i];
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [1:0] exp_pin();
    for (int i = 0; i < 2; i++) exp_pin[i] = m_start[i] ? m_run[i] : m_sw[i];
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(cur_req, "pins",  16'(pin_out),  16'(exp_pin()));
      chk(cur_req, "flags", 16'(flag_out), 16'({m_flag[1], m_flag[0]}));
      chk("R9",    "irq",   16'(irq_out),  16'({m_flag[1] & m_ie[1], m_flag[0] & m_ie[0]}));
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ctrl(logic [1:0] st, logic [1:0] bd, logic [1:0] ie, logic [1:0] fl);
    wr(3'd0, {8'h00, fl, ie, bd, st});
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic sweep(int ch, int lo, int hi);
    for (int v = lo; v <= hi; v++) begin
      c[ch] = 16'(v);
      @(negedge clk);
    end
  endtask

  logic [1:0] snap;

  initial begin
    c[0] = 16'h0; c[1] = 16'h0; c[2] = 16'h0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "pins", 16'(pin_out), 16'h0);
    chk("R1", "flags", 16'(flag_out), 16'h0);
    chk("R1", "irq", 16'(irq_out), 16'h0);
    run_cmp = 1'b1;

    // R4 / R12: disabled pins follow software data
    cur_req = "R4";
    wr(3'd2, 16'h0001);
    chk("R4", "pin after data write", 16'(pin_out), 16'h0001);
    wr(3'd2, 16'h0002);
    chk("R4", "pin after data write", 16'(pin_out), 16'h0002);
    wr(3'd2, 16'h0000);

    // R1 compare resets to 0xFFFF: enable ch0 with count at 0xFFFF
    cur_req = "R1";
    c[0] = 16'hFFFF;
    ctrl(2'b01, 2'b11, 2'b00, 2'b11);
    @(negedge clk);
    chk("R1", "ch0 toggles at 0xFFFF", 16'(pin_out), 16'h0001);
    chk("R8", "flag0 set", 16'(flag_out), 16'h0001);
    chk("R9", "irq masked", 16'(irq_out), 16'h0000);

    // R6 held equality gives one toggle only
    cur_req = "R6";
    idle(5);
    chk("R6", "no repeat toggle", 16'(pin_out), 16'h0001);

    // R8 flag write semantics
    cur_req = "R8";
    ctrl(2'b01, 2'b11, 2'b01, 2'b11);
    chk("R8", "write 1 keeps flag", 16'(flag_out), 16'h0001);
    chk("R9", "irq enabled", 16'(irq_out), 16'h0001);
    ctrl(2'b01, 2'b11, 2'b01, 2'b10);
    chk("R8", "write 0 clears", 16'(flag_out), 16'h0000);

    // R5 software data ignored while enabled
    cur_req = "R5";
    wr(3'd2, 16'h0000);
    idle(2);
    chk("R5", "pin ignores data write", 16'(pin_out[0]), 16'h0001);

    // R3 prohibited code: no match, no shadow load
    cur_req = "R3";
    c[0] = 16'h0000;
    @(negedge clk);
    wr(3'd1, 16'h0007);
    c[0] = 16'hFFFF;
    idle(4);
    chk("R3", "no match with code 7", 16'(pin_out[0]), 16'h0001);
    ctrl(2'b01, 2'b10, 2'b01, 2'b11);
    wr(3'd3, 16'h0030);
    zero_in = 3'b001; @(negedge clk); zero_in = 3'b000;
    wr(3'd1, 16'h0000);
    sweep(0, 0, 16'h3F);
    chk("R3", "shadow not loaded under code 7", 16'(pin_out[0]), 16'h0001);

    // R11 buffered load on the zero strobe
    cur_req = "R11";
    c[0] = 16'h0; zero_in = 3'b001; @(negedge clk); zero_in = 3'b000;
    sweep(0, 1, 16'h3F);
    chk("R11", "toggle at loaded 0x30", 16'(pin_out[0]), 16'h0000);

    // R10 immediate compare on ch1, count 1
    cur_req = "R10";
    wr(3'd1, 16'h0010);
    c[1] = 16'h0005;
    ctrl(2'b11, 2'b10, 2'b11, 2'b11);
    snap = pin_out;
    wr(3'd4, 16'h0005);
    @(negedge clk);
    chk("R10", "ch1 toggles next cycle", 16'(pin_out[1]), 16'(!snap[1]));
    chk("R9", "irq1", 16'(irq_out[1]), 16'h0001);

    // R2 ch1 on count 2: count 1 sweeps are ignored
    cur_req = "R2";
    wr(3'd1, 16'h0020);
    snap = pin_out;
    sweep(1, 0, 16'h10);
    chk("R2", "count1 ignored under code 2", 16'(pin_out[1]), 16'(snap[1]));
    sweep(2, 0, 16'h10);
    chk("R2", "count2 match toggles", 16'(pin_out[1]), 16'(!snap[1]));

    // R7 free-running sweeps checked against the model
    cur_req = "R7";
    for (int r = 0; r < 3; r++) begin
      sweep(0, 0, 16'h40);
      sweep(2, 0, 16'h08);
    end

    // R4 disable returns pins to software data
    cur_req = "R4";
    wr(3'd2, 16'h0003);
    ctrl(2'b00, 2'b11, 2'b00, 2'b11);
    chk("R4", "pins follow data after disable", 16'(pin_out), 16'h0003);
    wr(3'd2, 16'h0001);
    chk("R4", "pins follow new data", 16'(pin_out), 16'h0001);
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule